// File: doc/BRIEF.md
# Interrupt Vector Receive Latch

This block accepts sixteen level-sensitive legacy interrupt lines and turns them into single-entry vector interrupt deliveries to a processor. Each line goes through a fixed sparse table that assigns it a 6-bit vector number. Lines without an entry are ignored. A new rising edge on a mapped line, seen while the latch is empty, does five things:
- loads a three-word vector data register;
- sets a busy flag in the status register;
- raises the vector-interrupt request;
- presents the vector-interrupt trap code;
- pulses a wake signal for one cycle, to start a halted processor.

A falling edge on any mapped line while the latch is busy clears the flag, withdraws the request and the trap code, and leaves the data words as they were. The latch holds one entry and never queues. Rising edges that arrive while it is busy are lost.

Inputs are registered once, and each line's edges are found by comparing that sample with the one before it. The finite-state machine has two states. `ST_IDLE` is the empty latch and `ST_HELD` holds a delivered vector. Two transitions join them. `DELIVER` goes from `ST_IDLE` to `ST_HELD` on a mapped rising edge. `RELEASE` goes from `ST_HELD` to `ST_IDLE` on a mapped falling edge.

Top module: `ivec_latch`

## Requirements
- R1: After reset every output is zero and the latch is idle.
- R2: The mapping is: line 1 → 0x29, line 4 → 0x2B, line 6 → 0x27, line 7 → 0x22, line 12 → 0x2A. Edges on any other line have no effect on any output.
- R3: A rising edge on a mapped line while idle has the following effects, visible at the outputs on the second rising clock edge after the line changes:
  - status bit 5 is set and all other status bits stay 0;
  - `vec_req` rises;
  - `word0` becomes (0x1F << 6) | vector: bits 10:6 are all ones, bits 5:0 hold the vector and the upper bits are zero;
  - `word1` and `word2` become zero.
- R4: A rising edge on a mapped line while busy is dropped: the outputs do not change and there is no wake pulse.
- R5: A falling edge on any mapped line while busy clears status bit 5 and `vec_req`, two clock edges after the line change. `word0` keeps its last value.
- R6: A falling edge on a mapped line while idle has no effect on any output.
- R7: When several mapped lines rise in the same cycle while idle, the lowest-numbered one is delivered and the rest are dropped.
- R8: `trap_code` equals 0x060 while busy and 0 while idle.
- R9: `wake` is high for exactly the one cycle in which a delivery first becomes visible, and never at any other time.
- R10: Lines are edge-detected. A line that stays high does not cause a second delivery after the latch is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 16 | Level-sensitive legacy interrupt lines |
| status | output | 8 | Vector status; bit 5 = busy |
| word0 | output | 64 | Vector data word 0: {0, 5'h1F, vector} |
| word1 | output | 64 | Vector data word 1 (zero on delivery) |
| word2 | output | 64 | Vector data word 2 (zero on delivery) |
| vec_req | output | 1 | Vector interrupt request to the processor |
| trap_code | output | 9 | Pending trap code; 0x060 while busy |
| wake | output | 1 | One-cycle wake pulse on delivery |

## Verification
The hardest situation to reach from the ports is a line that is already high while the latch returns to idle. Its rising edge was swallowed while busy, and its later fall lands on an idle latch. The bench gets there in four steps:
1. It raises line 1 to make the latch busy.
2. It raises line 4 on top, which is dropped.
3. It lowers only line 1, which releases the latch while line 4 stays high.
4. It finally lowers line 4.

Steps 3 and 4 check that the held line neither re-delivers nor disturbs the idle latch. The bench also sweeps every single line and every pair of lines raised together. It checks the delivered vector against a priority computed independently from the mapping table.

// File: rtl/ivec_pkg.sv
package ivec_pkg;

    localparam int VEC_W = 6;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_HELD = 1'b1
    } latch_state_t;

    typedef struct packed {
        logic             hit;
        logic [VEC_W-1:0] vec;
    } line_map_t;

    // Sparse legacy line to vector table; unlisted lines are unmapped.
    function automatic line_map_t lookup_line(input int idx);
        line_map_t m;
        m.hit = 1'b1;
        case (idx)
            1:       m.vec = 6'h29;
            4:       m.vec = 6'h2B;
            6:       m.vec = 6'h27;
            7:       m.vec = 6'h22;
            12:      m.vec = 6'h2A;
            default: begin
                m.hit = 1'b0;
                m.vec = '0;
            end
        endcase
        return m;
    endfunction

endpackage

// File: rtl/ivec_edge.sv
module ivec_edge #(
    parameter int NLINES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] lines_in,
    output logic [NLINES-1:0] rise,
    output logic [NLINES-1:0] fall
);
    logic [NLINES-1:0] cur_q;
    logic [NLINES-1:0] old_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
            old_q <= '0;
        end else begin
            cur_q <= lines_in;
            old_q <= cur_q;
        end
    end

    for (genvar g = 0; g < NLINES; g++) begin : g_edge
        assign rise[g] = cur_q[g] & ~old_q[g];
        assign fall[g] = ~cur_q[g] & old_q[g];
    end
endmodule

// File: rtl/ivec_pick.sv
module ivec_pick
    import ivec_pkg::*;
#(
    parameter int NLINES = 16
) (
    input  logic [NLINES-1:0] rise,
    input  logic [NLINES-1:0] fall,
    output logic              rise_hit,
    output logic [VEC_W-1:0]  rise_vec,
    output logic              fall_hit
);
    logic [NLINES-1:0] mapped;
    logic [VEC_W-1:0]  vec_of [NLINES];

    for (genvar g = 0; g < NLINES; g++) begin : g_map
        localparam line_map_t ENTRY = lookup_line(g);
        assign mapped[g] = ENTRY.hit;
        assign vec_of[g] = ENTRY.vec;
    end

    logic [NLINES-1:0] rise_m;
    assign rise_m   = rise & mapped;
    assign fall_hit = |(fall & mapped);

    // Scan from the top down so the lowest-numbered line overrides.
    always_comb begin
        rise_hit = 1'b0;
        rise_vec = '0;
        for (int i = NLINES - 1; i >= 0; i--) begin
            if (rise_m[i]) begin
                rise_hit = 1'b1;
                rise_vec = vec_of[i];
            end
        end
    end
endmodule

// File: rtl/ivec_latch.sv
module ivec_latch
    import ivec_pkg::*;
#(
    parameter int             NLINES    = 16,
    parameter int             WORD_W    = 64,
    parameter int             STAT_W    = 8,
    parameter int             BUSY_BIT  = 5,
    parameter int             TRAP_W    = 9,
    parameter logic [TRAP_W-1:0] TRAP_VEC = 9'h060
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] irq_lines,
    output logic [STAT_W-1:0] status,
    output logic [WORD_W-1:0] word0,
    output logic [WORD_W-1:0] word1,
    output logic [WORD_W-1:0] word2,
    output logic              vec_req,
    output logic [TRAP_W-1:0] trap_code,
    output logic              wake
);
    localparam logic [4:0] MARK_FIELD = 5'h1F;
    localparam int         PACK_W     = 5 + VEC_W;

    logic [NLINES-1:0] rise, fall;
    logic              rise_hit, fall_hit;
    logic [VEC_W-1:0]  rise_vec;

    ivec_edge #(.NLINES(NLINES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .lines_in (irq_lines),
        .rise     (rise),
        .fall     (fall)
    );

    ivec_pick #(.NLINES(NLINES)) u_pick (
        .rise     (rise),
        .fall     (fall),
        .rise_hit (rise_hit),
        .rise_vec (rise_vec),
        .fall_hit (fall_hit)
    );

    latch_state_t state, state_nxt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (rise_hit) state_nxt = ST_HELD;   // DELIVER
            ST_HELD: if (fall_hit) state_nxt = ST_IDLE;   // RELEASE
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Registered outputs, updated on the named transitions only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word0     <= '0;
            word1     <= '0;
            word2     <= '0;
            trap_code <= '0;
            wake      <= 1'b0;
        end else begin
            wake <= 1'b0;
            unique case (state)
                ST_IDLE: if (rise_hit) begin
                    word0     <= WORD_W'({MARK_FIELD, rise_vec});
                    word1     <= '0;
                    word2     <= '0;
                    trap_code <= TRAP_VEC;
                    wake      <= 1'b1;
                end
                ST_HELD: if (fall_hit) begin
                    trap_code <= '0;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        status           = '0;
        status[BUSY_BIT] = (state == ST_HELD);
    end
    assign vec_req = (state == ST_HELD);

    // Width guard for the packed data word.
    if (PACK_W > WORD_W) begin : g_bad_width
        initial $error("data word too narrow");
    end
endmodule

// File: rtl/ivec_latch_chk.sv
module ivec_latch_chk #(
    parameter int NLINES = 16,
    parameter int WORD_W = 64,
    parameter int STAT_W = 8,
    parameter int BUSY_BIT = 5,
    parameter int TRAP_W = 9,
    parameter logic [TRAP_W-1:0] TRAP_VEC = 9'h060
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NLINES-1:0] irq_lines,
    input logic [STAT_W-1:0] status,
    input logic [WORD_W-1:0] word0,
    input logic [WORD_W-1:0] word1,
    input logic [WORD_W-1:0] word2,
    input logic              vec_req,
    input logic [TRAP_W-1:0] trap_code,
    input logic              wake
);
    logic busy;
    assign busy = status[BUSY_BIT];

    // R1: only the busy bit may ever be set in the status register
    assert_status_clean_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (status & ~(STAT_W'(1) << BUSY_BIT)) == '0);

    // R3: a new delivery carries the marker field and zeroed upper words
    assert_deliver_format_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (word0[10:6] == 5'h1F && word1 == '0 && word2 == '0 && vec_req));

    // R4: while the latch stays busy the data word does not move
    assert_busy_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(word0));

    // R8: trap code follows the busy flag
    assert_trap_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        trap_code == (busy ? TRAP_VEC : '0));

    // R9: wake marks the idle-to-busy step and lasts one cycle
    assert_wake_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> (busy && !$past(busy)));
    assert_wake_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> !wake);
endmodule

bind ivec_latch ivec_latch_chk #(
    .NLINES(NLINES), .WORD_W(WORD_W), .STAT_W(STAT_W),
    .BUSY_BIT(BUSY_BIT), .TRAP_W(TRAP_W), .TRAP_VEC(TRAP_VEC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .status(status),
    .word0(word0), .word1(word1), .word2(word2), .vec_req(vec_req),
    .trap_code(trap_code), .wake(wake)
);

// File: tb/ivec_latch_bench.sv
module ivec_latch_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_lines = '0;
    logic [7:0]  status;
    logic [63:0] word0, word1, word2;
    logic        vec_req, wake;
    logic [8:0]  trap_code;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic [63:0] exp_w0 = '0;

    always #4 clk = ~clk;

    ivec_latch u_ivec_latch (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .status(status),
        .word0(word0), .word1(word1), .word2(word2), .vec_req(vec_req),
        .trap_code(trap_code), .wake(wake)
    );

    function automatic int vec_of(input int line);
        case (line)
            1:  return 'h29;
            4:  return 'h2B;
            6:  return 'h27;
            7:  return 'h22;
            12: return 'h2A;
            default: return -1;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive at a falling edge, then sample two falling edges later.
    task automatic drive(input logic [15:0] v);
        @(negedge clk);
        irq_lines = v;
        repeat (2) @(negedge clk);
    endtask

    task automatic chk_state(input string tag, input bit busy, input bit wk);
        chk({tag, " status"}, 64'(status), busy ? 64'h20 : 64'h0);
        chk({tag, " vec_req"}, 64'(vec_req), 64'(busy));
        chk({tag, " trap"}, 64'(trap_code), busy ? 64'h060 : 64'h0);
        chk({tag, " wake"}, 64'(wake), 64'(wk));
        chk({tag, " word0"}, word0, exp_w0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk_state("R1 reset", 1'b0, 1'b0);
        chk("R1 word1", word1, 64'h0);
        chk("R1 word2", word2, 64'h0);
        rst_n = 1'b1;

        // Single-line sweep (R2, R3, R5, R9)
        for (int i = 0; i < 16; i++) begin
            int v;
            v = vec_of(i);
            drive(16'(1) << i);
            if (v >= 0) begin
                exp_w0 = 64'h7C0 | 64'(v);
                chk_state("R3 deliver", 1'b1, 1'b1);
                chk("R3 word1", word1, 64'h0);
                chk("R3 word2", word2, 64'h0);
                @(negedge clk);
                chk("R9 wake drops", 64'(wake), 64'h0);
                drive('0);
                chk_state("R5 release", 1'b0, 1'b0);
            end else begin
                chk_state("R2 unmapped rise", 1'b0, 1'b0);
                drive('0);
                chk_state("R2 unmapped fall", 1'b0, 1'b0);
            end
        end

        // Pair sweep (R7)
        for (int i = 0; i < 16; i++) begin
            for (int j = i + 1; j < 16; j++) begin
                int win;
                win = -1;
                if (vec_of(j) >= 0) win = vec_of(j);
                if (vec_of(i) >= 0) win = vec_of(i);
                drive((16'(1) << i) | (16'(1) << j));
                if (win >= 0) begin
                    exp_w0 = 64'h7C0 | 64'(win);
                    chk_state("R7 pair", 1'b1, 1'b1);
                end else begin
                    chk_state("R7 pair unmapped", 1'b0, 1'b0);
                end
                drive('0);
                chk_state("R7 pair release", 1'b0, 1'b0);
            end
        end

        // Busy drop, held line, idle fall (R4, R5, R10, R6)
        drive(16'h0002);
        exp_w0 = 64'h7E9;
        chk_state("R3 line1", 1'b1, 1'b1);
        drive(16'h0012);
        chk_state("R4 raise while busy", 1'b1, 1'b0);
        drive(16'h0010);
        chk_state("R5 release by line1", 1'b0, 1'b0);
        repeat (4) @(negedge clk);
        chk_state("R10 held line no redeliver", 1'b0, 1'b0);
        drive(16'h0000);
        chk_state("R6 fall while idle", 1'b0, 1'b0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule